// File: doc/BRIEF.md
# Processor Status Word Condition Flag Unit

This block holds the 16-bit processor status word of a small processor core. On every executed instruction it derives the negative, zero, overflow, carry and end-of-table flags from the operation class, the operand size, the two operands and the ALU result with its carry. It then writes only the flags that this class defines into the status register. A multiply/divide-interrupted status bit is kept next to the flags. It is set and cleared by pulses from the sequencer. The remaining upper bits of the word are plain storage for fields owned by other logic.

An instruction that writes the status word directly wins over every implicit update in the same cycle. The registered word on `psw` always shows the state after the previous instruction. Byte operations look only at the low byte of each operand and of the result. Single-bit and bit-pair operations give the negative flag a meaning of its own.

Top module: `psw_flag_unit`

## Requirements
- R1: `psw` bit layout is N=0, Z=1, V=2, C=3, E=4, MULIP=5, with bits 15:6 as stored fields. An active-low `rst_n` clears all 16 bits to zero at once.
- R2: For add, subtract, compare, logical and move, N takes the result MSB: bit 15 in word mode, bit 7 in byte mode.
- R3: For add, subtract, compare, logical and move, Z is set exactly when the size-masked result is zero.
- R4: `alu_carry` is the carry out of the MSB of the selected size. Add copies it to C. Subtract and compare store its inverse as a borrow. Logical clears C and V. Move leaves C and V unchanged.
- R5: V flags signed overflow. For add, it is set when the operands share a sign and the result sign differs from them. For subtract and compare (`dst_opnd` minus `src_opnd`), it is set when the operand signs differ and the result sign differs from `dst_opnd`.
- R6: For add, subtract, compare, logical and move, E is set exactly when the size-masked `src_opnd` is the most negative value: 8000h in word mode, 80h in byte mode.
- R7: For a single-bit operation, N becomes `dst_opnd[bit_a]` as it was before. For a bit-pair operation, N becomes `dst_opnd[bit_a]` XOR `src_opnd[bit_b]`. Both leave Z, V, C and E unchanged.
- R8: A `mulip_set` pulse sets MULIP and a `mulip_clr` pulse clears it. When both arrive together, set wins. Neither pulse touches any other bit.
- R9: When `psw_wr_en` is high, the next `psw` equals `psw_wr_data` in full. This overrides the implicit flags and the MULIP pulses of that cycle.
- R10: Operation codes are 0 none, 1 add, 2 subtract, 3 compare, 4 logical, 5 move, 6 single-bit, 7 bit-pair. Flags change only on a clock edge with `instr_valid` high, so `psw` still shows the previous state during the instruction's own cycle. With `instr_valid` low or code 0, the flags hold.
- R11: Bits 15:6 of `psw` change only through an explicit write.
- R12: In byte mode, bits 15:8 of the operands and of the result have no effect on any flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_valid | input | 1 | An instruction completes in this cycle |
| op_class | input | 3 | Operation class code |
| byte_mode | input | 1 | 1 = byte operation, 0 = word operation |
| src_opnd | input | 16 | Source operand |
| dst_opnd | input | 16 | Destination operand (minuend for subtract) |
| alu_result | input | 16 | ALU result |
| alu_carry | input | 1 | Carry out of the MSB of the selected size |
| bit_a | input | 4 | Bit index into `dst_opnd` for bit operations |
| bit_b | input | 4 | Bit index into `src_opnd` for bit-pair operations |
| psw_wr_en | input | 1 | Explicit status word write |
| psw_wr_data | input | 16 | Value for the explicit write |
| mulip_set | input | 1 | Multiply/divide interrupted pulse |
| mulip_clr | input | 1 | Multiply/divide resume complete pulse |
| psw | output | 16 | Registered status word |

## Verification
The bound checker watches several rules on every cycle. It checks that an explicit write lands in full, and that the word holds when nothing is active. It checks that the stored upper fields stay put, and that MULIP follows its pulses. For word operations it checks E and Z, and it checks the borrow inversion, the add carry and both bit-operation meanings of N. Overflow signs, byte masking against junk in the upper bytes, the keep-or-clear choice for C and V per class, and the reset value can only be shown by the bench scenarios. These are the prefilled-state vectors and the directed cases.

// File: rtl/psw_pkg.sv
`timescale 1ns/1ps
package psw_pkg;

   typedef enum logic [2:0] {
      OPC_NONE  = 3'd0,
      OPC_ADD   = 3'd1,
      OPC_SUB   = 3'd2,
      OPC_CMP   = 3'd3,
      OPC_LOGIC = 3'd4,
      OPC_MOVE  = 3'd5,
      OPC_BIT1  = 3'd6,
      OPC_BIT2  = 3'd7
   } psw_opc_e;

   // status word bit positions; condition flags are contiguous from FLAG_LSB
   localparam int unsigned PSW_N        = 0;
   localparam int unsigned PSW_Z        = 1;
   localparam int unsigned PSW_V        = 2;
   localparam int unsigned PSW_C        = 3;
   localparam int unsigned PSW_E        = 4;
   localparam int unsigned PSW_MIP      = 5;
   localparam int unsigned FLAG_LSB     = PSW_N;
   localparam int unsigned FLAG_CNT     = 5;
   localparam int unsigned PSW_MIN_W    = PSW_MIP + 1;

   // packed so that bit i of the vector is the flag at FLAG_LSB+i
   typedef struct packed {
      logic e;
      logic c;
      logic v;
      logic z;
      logic n;
   } cond_flags_t;

endpackage

// File: rtl/psw_size_view.sv
`timescale 1ns/1ps
module psw_size_view #(
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned BYTE_W  = 8,
   parameter bit          BYTE_EN = 1'b1
) (
   input  logic              byte_sel,
   input  logic [DATA_W-1:0] src,
   input  logic [DATA_W-1:0] dst,
   input  logic [DATA_W-1:0] res,
   output logic              res_msb,
   output logic              src_msb,
   output logic              dst_msb,
   output logic              res_zero,
   output logic              src_min
);

   localparam logic [DATA_W-1:0] WORD_MIN = {1'b1, {(DATA_W-1){1'b0}}};
   localparam logic [BYTE_W-1:0] BYTE_MIN = {1'b1, {(BYTE_W-1){1'b0}}};

   logic w_res_msb, w_src_msb, w_dst_msb, w_res_zero, w_src_min;

   assign w_res_msb  = res[DATA_W-1];
   assign w_src_msb  = src[DATA_W-1];
   assign w_dst_msb  = dst[DATA_W-1];
   assign w_res_zero = ~|res;
   assign w_src_min  = (src == WORD_MIN);

   generate
      if (BYTE_EN) begin : g_byte
         logic b_res_msb, b_src_msb, b_dst_msb, b_res_zero, b_src_min;

         assign b_res_msb  = res[BYTE_W-1];
         assign b_src_msb  = src[BYTE_W-1];
         assign b_dst_msb  = dst[BYTE_W-1];
         assign b_res_zero = ~|res[BYTE_W-1:0];
         assign b_src_min  = (src[BYTE_W-1:0] == BYTE_MIN);

         always_comb begin
            if (byte_sel) begin
               res_msb  = b_res_msb;
               src_msb  = b_src_msb;
               dst_msb  = b_dst_msb;
               res_zero = b_res_zero;
               src_min  = b_src_min;
            end else begin
               res_msb  = w_res_msb;
               src_msb  = w_src_msb;
               dst_msb  = w_dst_msb;
               res_zero = w_res_zero;
               src_min  = w_src_min;
            end
         end
      end else begin : g_word
         logic unused_sel;
         assign unused_sel = byte_sel;
         assign res_msb  = w_res_msb;
         assign src_msb  = w_src_msb;
         assign dst_msb  = w_dst_msb;
         assign res_zero = w_res_zero;
         assign src_min  = w_src_min;
      end
   endgenerate

endmodule

// File: rtl/psw_bit_pick.sv
`timescale 1ns/1ps
module psw_bit_pick #(
   parameter int unsigned DATA_W = 16,
   localparam int unsigned IDX_W = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] src,
   input  logic [DATA_W-1:0] dst,
   input  logic [IDX_W-1:0]  idx_a,
   input  logic [IDX_W-1:0]  idx_b,
   output logic              single_bit,
   output logic              pair_xor
);

   logic [DATA_W-1:0] dec_a, dec_b;
   logic sel_a, sel_b;

   // one-hot decode followed by a reduction, one term per bit position
   generate
      for (genvar i = 0; i < DATA_W; i++) begin : g_dec
         assign dec_a[i] = (idx_a == IDX_W'(i)) & dst[i];
         assign dec_b[i] = (idx_b == IDX_W'(i)) & src[i];
      end
   endgenerate

   assign sel_a      = |dec_a;
   assign sel_b      = |dec_b;
   assign single_bit = sel_a;
   assign pair_xor   = sel_a ^ sel_b;

endmodule

// File: rtl/psw_flag_calc.sv
`timescale 1ns/1ps
module psw_flag_calc
   import psw_pkg::*;
(
   input  psw_opc_e    opc,
   input  logic        res_msb,
   input  logic        src_msb,
   input  logic        dst_msb,
   input  logic        res_zero,
   input  logic        src_min,
   input  logic        carry,
   input  logic        single_bit,
   input  logic        pair_xor,
   output cond_flags_t val,
   output cond_flags_t upd
);

   logic add_ovf, sub_ovf;

   assign add_ovf = (src_msb == dst_msb) && (res_msb != dst_msb);
   assign sub_ovf = (src_msb != dst_msb) && (res_msb != dst_msb);

   always_comb begin
      val = '0;
      upd = '0;
      unique case (opc)
         OPC_ADD: begin
            val = '{e: src_min, c: carry, v: add_ovf, z: res_zero, n: res_msb};
            upd = '1;
         end
         OPC_SUB, OPC_CMP: begin
            val = '{e: src_min, c: ~carry, v: sub_ovf, z: res_zero, n: res_msb};
            upd = '1;
         end
         OPC_LOGIC: begin
            val = '{e: src_min, c: 1'b0, v: 1'b0, z: res_zero, n: res_msb};
            upd = '1;
         end
         OPC_MOVE: begin
            val = '{e: src_min, c: 1'b0, v: 1'b0, z: res_zero, n: res_msb};
            upd = '{e: 1'b1, c: 1'b0, v: 1'b0, z: 1'b1, n: 1'b1};
         end
         OPC_BIT1: begin
            val.n = single_bit;
            upd.n = 1'b1;
         end
         OPC_BIT2: begin
            val.n = pair_xor;
            upd.n = 1'b1;
         end
         default: begin
            val = '0;
            upd = '0;
         end
      endcase
   end

endmodule

// File: rtl/psw_state_reg.sv
`timescale 1ns/1ps
module psw_state_reg
   import psw_pkg::*;
#(
   parameter int unsigned PSW_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             instr_valid,
   input  cond_flags_t      flag_val,
   input  cond_flags_t      flag_upd,
   input  logic             mulip_set,
   input  logic             mulip_clr,
   input  logic             wr_en,
   input  logic [PSW_W-1:0] wr_data,
   output logic [PSW_W-1:0] psw_q
);

   logic [FLAG_CNT-1:0] fv, fm;
   logic [PSW_W-1:0]    imp_val, imp_mask, psw_d;

   assign fv = flag_val;
   assign fm = flag_upd;

   // place the flag vector at its word positions; all other bits stay masked
   generate
      for (genvar i = 0; i < PSW_W; i++) begin : g_place
         if (i >= FLAG_LSB && i < FLAG_LSB + FLAG_CNT) begin : g_flag
            assign imp_val[i]  = fv[i - FLAG_LSB];
            assign imp_mask[i] = fm[i - FLAG_LSB] & instr_valid;
         end else begin : g_fixed
            assign imp_val[i]  = 1'b0;
            assign imp_mask[i] = 1'b0;
         end
      end
   endgenerate

   always_comb begin
      psw_d = (psw_q & ~imp_mask) | (imp_val & imp_mask);
      if (mulip_set)
         psw_d[PSW_MIP] = 1'b1;
      else if (mulip_clr)
         psw_d[PSW_MIP] = 1'b0;
      if (wr_en)
         psw_d = wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         psw_q <= '0;
      else
         psw_q <= psw_d;
   end

endmodule

// File: rtl/psw_flag_unit.sv
`timescale 1ns/1ps
module psw_flag_unit
   import psw_pkg::*;
#(
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned BYTE_W  = 8,
   parameter int unsigned PSW_W   = 16,
   parameter bit          BYTE_EN = 1'b1,
   localparam int unsigned IDX_W  = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              instr_valid,
   input  logic [2:0]        op_class,
   input  logic              byte_mode,
   input  logic [DATA_W-1:0] src_opnd,
   input  logic [DATA_W-1:0] dst_opnd,
   input  logic [DATA_W-1:0] alu_result,
   input  logic              alu_carry,
   input  logic [IDX_W-1:0]  bit_a,
   input  logic [IDX_W-1:0]  bit_b,
   input  logic              psw_wr_en,
   input  logic [PSW_W-1:0]  psw_wr_data,
   input  logic              mulip_set,
   input  logic              mulip_clr,
   output logic [PSW_W-1:0]  psw
);

   generate
      if (BYTE_W < 2 || BYTE_W >= DATA_W) begin : g_bad_byte
         $error("psw_flag_unit: BYTE_W must lie in [2, DATA_W)");
      end
      if ((DATA_W & (DATA_W - 1)) != 0) begin : g_bad_data
         $error("psw_flag_unit: DATA_W must be a power of two");
      end
      if (PSW_W < PSW_MIN_W) begin : g_bad_psw
         $error("psw_flag_unit: PSW_W too small for the flag layout");
      end
   endgenerate

   psw_opc_e    opc;
   logic        res_msb, src_msb, dst_msb, res_zero, src_min;
   logic        single_bit, pair_xor;
   cond_flags_t flag_val, flag_upd;

   assign opc = psw_opc_e'(op_class);

   psw_size_view #(
      .DATA_W  (DATA_W),
      .BYTE_W  (BYTE_W),
      .BYTE_EN (BYTE_EN)
   ) u_view (
      .byte_sel (byte_mode),
      .src      (src_opnd),
      .dst      (dst_opnd),
      .res      (alu_result),
      .res_msb  (res_msb),
      .src_msb  (src_msb),
      .dst_msb  (dst_msb),
      .res_zero (res_zero),
      .src_min  (src_min)
   );

   psw_bit_pick #(
      .DATA_W (DATA_W)
   ) u_pick (
      .src        (src_opnd),
      .dst        (dst_opnd),
      .idx_a      (bit_a),
      .idx_b      (bit_b),
      .single_bit (single_bit),
      .pair_xor   (pair_xor)
   );

   psw_flag_calc u_calc (
      .opc        (opc),
      .res_msb    (res_msb),
      .src_msb    (src_msb),
      .dst_msb    (dst_msb),
      .res_zero   (res_zero),
      .src_min    (src_min),
      .carry      (alu_carry),
      .single_bit (single_bit),
      .pair_xor   (pair_xor),
      .val        (flag_val),
      .upd        (flag_upd)
   );

   psw_state_reg #(
      .PSW_W (PSW_W)
   ) u_reg (
      .clk         (clk),
      .rst_n       (rst_n),
      .instr_valid (instr_valid),
      .flag_val    (flag_val),
      .flag_upd    (flag_upd),
      .mulip_set   (mulip_set),
      .mulip_clr   (mulip_clr),
      .wr_en       (psw_wr_en),
      .wr_data     (psw_wr_data),
      .psw_q       (psw)
   );

endmodule

// File: rtl/psw_flag_checker.sv
`timescale 1ns/1ps
module psw_flag_checker
   import psw_pkg::*;
#(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned PSW_W  = 16,
   localparam int unsigned IDX_W = $clog2(DATA_W)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              instr_valid,
   input logic [2:0]        op_class,
   input logic              byte_mode,
   input logic [DATA_W-1:0] src_opnd,
   input logic [DATA_W-1:0] dst_opnd,
   input logic [DATA_W-1:0] alu_result,
   input logic              alu_carry,
   input logic [IDX_W-1:0]  bit_a,
   input logic [IDX_W-1:0]  bit_b,
   input logic              psw_wr_en,
   input logic [PSW_W-1:0]  psw_wr_data,
   input logic              mulip_set,
   input logic              mulip_clr,
   input logic [PSW_W-1:0]  psw
);

   localparam logic [DATA_W-1:0] WMIN = {1'b1, {(DATA_W-1){1'b0}}};

   logic imp_go, arith_cls, sub_cls, quiet, dst_bit, pair_bit;

   assign imp_go    = instr_valid && !psw_wr_en;
   assign arith_cls = (op_class >= 3'(OPC_ADD)) && (op_class <= 3'(OPC_MOVE));
   assign sub_cls   = (op_class == 3'(OPC_SUB)) || (op_class == 3'(OPC_CMP));
   assign quiet     = !instr_valid && !psw_wr_en && !mulip_set && !mulip_clr;
   assign dst_bit   = dst_opnd[bit_a];
   assign pair_bit  = dst_opnd[bit_a] ^ src_opnd[bit_b];

   assert_wr_override_R9: assert property (@(posedge clk) disable iff (!rst_n)
      psw_wr_en |=> psw == $past(psw_wr_data));

   assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      quiet |=> $stable(psw));

   assert_upper_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !psw_wr_en |=> $stable(psw[PSW_W-1:PSW_MIN_W]));

   assert_e_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (imp_go && arith_cls && !byte_mode) |=> psw[PSW_E] == $past(src_opnd == WMIN));

   assert_z_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (imp_go && arith_cls && !byte_mode) |=> psw[PSW_Z] == $past(alu_result == '0));

   assert_borrow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (imp_go && sub_cls) |=> psw[PSW_C] == !$past(alu_carry));

   assert_add_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (imp_go && op_class == 3'(OPC_ADD)) |=> psw[PSW_C] == $past(alu_carry));

   assert_mulip_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!psw_wr_en && mulip_set) |=> psw[PSW_MIP]);

   assert_mulip_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!psw_wr_en && mulip_clr && !mulip_set) |=> !psw[PSW_MIP]);

   assert_bit1_n_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (imp_go && op_class == 3'(OPC_BIT1)) |=> psw[PSW_N] == $past(dst_bit));

   assert_bit2_n_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (imp_go && op_class == 3'(OPC_BIT2)) |=> psw[PSW_N] == $past(pair_bit));

endmodule

bind psw_flag_unit psw_flag_checker #(
   .DATA_W (DATA_W),
   .PSW_W  (PSW_W)
) u_flag_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .instr_valid (instr_valid),
   .op_class    (op_class),
   .byte_mode   (byte_mode),
   .src_opnd    (src_opnd),
   .dst_opnd    (dst_opnd),
   .alu_result  (alu_result),
   .alu_carry   (alu_carry),
   .bit_a       (bit_a),
   .bit_b       (bit_b),
   .psw_wr_en   (psw_wr_en),
   .psw_wr_data (psw_wr_data),
   .mulip_set   (mulip_set),
   .mulip_clr   (mulip_clr),
   .psw         (psw)
);

// File: tb/psw_flag_unit_test.sv
`timescale 1ns/1ps
module psw_flag_unit_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        instr_valid = 1'b0;
   logic [2:0]  op_class = 3'd0;
   logic        byte_mode = 1'b0;
   logic [15:0] src_opnd = '0;
   logic [15:0] dst_opnd = '0;
   logic [15:0] alu_result = '0;
   logic        alu_carry = 1'b0;
   logic [3:0]  bit_a = '0;
   logic [3:0]  bit_b = '0;
   logic        psw_wr_en = 1'b0;
   logic [15:0] psw_wr_data = '0;
   logic        mulip_set = 1'b0;
   logic        mulip_clr = 1'b0;
   logic [15:0] psw;

   int tests_run = 0;
   int tests_failed = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   psw_flag_unit uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .instr_valid (instr_valid),
      .op_class    (op_class),
      .byte_mode   (byte_mode),
      .src_opnd    (src_opnd),
      .dst_opnd    (dst_opnd),
      .alu_result  (alu_result),
      .alu_carry   (alu_carry),
      .bit_a       (bit_a),
      .bit_b       (bit_b),
      .psw_wr_en   (psw_wr_en),
      .psw_wr_data (psw_wr_data),
      .mulip_set   (mulip_set),
      .mulip_clr   (mulip_clr),
      .psw         (psw)
   );

   typedef struct packed {
      logic [15:0] pre;
      logic [2:0]  op;
      logic        byt;
      logic [15:0] src;
      logic [15:0] dst;
      logic [15:0] res;
      logic        cy;
      logic [3:0]  ia;
      logic [3:0]  ib;
      logic [5:0]  exp;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 19;
   // exp holds bits 5:0 (N0 Z1 V2 C3 E4 MULIP5); bits 15:6 must keep pre (R11)
   localparam vec_t VECS [NV] = '{
      '{16'hA000, 3'd1, 1'b0, 16'h0001, 16'h7FFF, 16'h8000, 1'b0, 4'd0, 4'd0, 6'h05, 4'd5},  // R5 add overflow, R2 N
      '{16'h4000, 3'd1, 1'b0, 16'hFFFF, 16'h0001, 16'h0000, 1'b1, 4'd0, 4'd0, 6'h0A, 4'd3},  // R3 zero, R4 carry
      '{16'h0000, 3'd2, 1'b0, 16'h0007, 16'h0005, 16'hFFFE, 1'b0, 4'd0, 4'd0, 6'h09, 4'd4},  // R4 borrow
      '{16'h1240, 3'd2, 1'b0, 16'h0001, 16'h8000, 16'h7FFF, 1'b1, 4'd0, 4'd0, 6'h04, 4'd5},  // R5 sub overflow
      '{16'h0015, 3'd3, 1'b0, 16'h1234, 16'h1234, 16'h0000, 1'b1, 4'd0, 4'd0, 6'h02, 4'd3},  // R3 compare equal
      '{16'h0000, 3'd3, 1'b0, 16'h8000, 16'h0000, 16'h8000, 1'b0, 4'd0, 4'd0, 6'h1D, 4'd6},  // R6 word min
      '{16'h8000, 3'd1, 1'b1, 16'h0080, 16'h0080, 16'h0100, 1'b1, 4'd0, 4'd0, 6'h1E, 4'd12}, // R12 byte add
      '{16'h001F, 3'd1, 1'b1, 16'hFF01, 16'h7F7E, 16'hFE7F, 1'b0, 4'd0, 4'd0, 6'h00, 4'd12}, // R12 junk upper
      '{16'h000C, 3'd4, 1'b0, 16'h8000, 16'h1234, 16'h0000, 1'b0, 4'd0, 4'd0, 6'h12, 4'd4},  // R4 logic clears
      '{16'h0000, 3'd4, 1'b1, 16'h0011, 16'h00FF, 16'h0080, 1'b0, 4'd0, 4'd0, 6'h01, 4'd2},  // R2 byte MSB
      '{16'h000C, 3'd5, 1'b0, 16'h8000, 16'h0000, 16'h8000, 1'b0, 4'd0, 4'd0, 6'h1D, 4'd4},  // R4 move keeps
      '{16'h0000, 3'd5, 1'b1, 16'hAB00, 16'h0000, 16'hAB00, 1'b0, 4'd0, 4'd0, 6'h02, 4'd12}, // R12 byte move
      '{16'h001E, 3'd6, 1'b0, 16'h0000, 16'h0010, 16'h0000, 1'b0, 4'd4, 4'd0, 6'h1F, 4'd7},  // R7 single set
      '{16'h0001, 3'd6, 1'b0, 16'h0000, 16'hFFEF, 16'h0000, 1'b0, 4'd4, 4'd0, 6'h00, 4'd7},  // R7 single clear
      '{16'h0021, 3'd7, 1'b0, 16'h0001, 16'h8000, 16'h0000, 1'b0, 4'd15, 4'd0, 6'h20, 4'd7}, // R7 pair equal
      '{16'h0000, 3'd7, 1'b0, 16'h0004, 16'h0000, 16'h0000, 1'b0, 4'd3, 4'd2, 6'h01, 4'd7},  // R7 pair differ
      '{16'h0015, 3'd0, 1'b0, 16'h8000, 16'h0000, 16'h0000, 1'b1, 4'd0, 4'd0, 6'h15, 4'd10}, // R10 code none
      '{16'hC000, 3'd2, 1'b1, 16'h0020, 16'h0010, 16'h00F0, 1'b0, 4'd0, 4'd0, 6'h09, 4'd4},  // R4 byte borrow
      '{16'h0000, 3'd2, 1'b1, 16'h0001, 16'h0080, 16'h007F, 1'b1, 4'd0, 4'd0, 6'h04, 4'd5}   // R5 byte overflow
   };

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      tests_run++;
      if (act !== exp) begin
         tests_failed++;
         $display("FAIL %s: psw=%h expected %h", req, act, exp);
      end
   endtask

   task automatic drive_instr(input logic [2:0] op, input logic byt, input logic [15:0] s,
                              input logic [15:0] d, input logic [15:0] r, input logic cy,
                              input logic [3:0] ia, input logic [3:0] ib);
      instr_valid = 1'b1;
      op_class    = op;
      byte_mode   = byt;
      src_opnd    = s;
      dst_opnd    = d;
      alu_result  = r;
      alu_carry   = cy;
      bit_a       = ia;
      bit_b       = ib;
   endtask

   task automatic idle_inputs();
      instr_valid = 1'b0;
      psw_wr_en   = 1'b0;
      mulip_set   = 1'b0;
      mulip_clr   = 1'b0;
   endtask

   task automatic load_psw(input logic [15:0] v);
      @(negedge clk);
      idle_inputs();
      psw_wr_en   = 1'b1;
      psw_wr_data = v;
      @(negedge clk);
      psw_wr_en = 1'b0;
   endtask

   initial begin
      #2_000_000;
      if (!finished) begin
         tests_failed++;
         tests_run++;
         $display("FAIL watchdog: run hung, act=timeout expected=done");
         $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset value", psw, 16'h0000);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", psw, 16'h0000);

      // vector table
      for (int i = 0; i < NV; i++) begin
         load_psw(VECS[i].pre);
         drive_instr(VECS[i].op, VECS[i].byt, VECS[i].src, VECS[i].dst,
                     VECS[i].res, VECS[i].cy, VECS[i].ia, VECS[i].ib);
         // R10: during the instruction cycle the previous state is visible
         check("R10 pre-edge view", psw, VECS[i].pre);
         @(negedge clk);
         idle_inputs();
         tests_run++;
         if (psw !== {VECS[i].pre[15:6], VECS[i].exp}) begin
            tests_failed++;
            $display("FAIL R%0d vector %0d: psw=%h expected %h", VECS[i].req, i, psw,
                     {VECS[i].pre[15:6], VECS[i].exp});
         end
      end

      // R9: explicit write beats an add and a MULIP set in the same cycle
      load_psw(16'h0000);
      drive_instr(3'd1, 1'b0, 16'h8000, 16'h8000, 16'h0000, 1'b1, 4'd0, 4'd0);
      psw_wr_en   = 1'b1;
      psw_wr_data = 16'h5A5A;
      mulip_set   = 1'b1;
      @(negedge clk);
      idle_inputs();
      check("R9 write priority", psw, 16'h5A5A);

      // R10: instr_valid low leaves the word alone
      drive_instr(3'd1, 1'b0, 16'h8000, 16'h8000, 16'h0000, 1'b1, 4'd0, 4'd0);
      instr_valid = 1'b0;
      @(negedge clk);
      check("R10 idle hold", psw, 16'h5A5A);

      // R8: MULIP pulses
      load_psw(16'h600B);
      mulip_set = 1'b1;
      @(negedge clk);
      mulip_set = 1'b0;
      check("R8 mulip set", psw, 16'h602B);
      mulip_clr = 1'b1;
      @(negedge clk);
      mulip_clr = 1'b0;
      check("R8 mulip clear", psw, 16'h600B);
      mulip_set = 1'b1;
      mulip_clr = 1'b1;
      @(negedge clk);
      idle_inputs();
      check("R8 set wins", psw, 16'h602B);

      // R8 with R2: pulse alongside a move that updates N and Z
      drive_instr(3'd5, 1'b0, 16'h0001, 16'h0000, 16'h0000, 1'b0, 4'd0, 4'd0);
      mulip_clr = 1'b1;
      @(negedge clk);
      idle_inputs();
      check("R8 clear with move", psw, 16'h600A);

      // R11: many implicit ops never reach the upper fields
      load_psw(16'hFFC0);
      drive_instr(3'd1, 1'b0, 16'hFFFF, 16'hFFFF, 16'hFFFE, 1'b1, 4'd0, 4'd0);
      @(negedge clk);
      drive_instr(3'd4, 1'b0, 16'h0000, 16'h0000, 16'h0000, 1'b0, 4'd0, 4'd0);
      @(negedge clk);
      idle_inputs();
      check("R11 upper kept", psw, 16'hFFC2);

      // R1: asynchronous reset in mid run
      load_psw(16'hFFFF);
      #2;
      rst_n = 1'b0;
      #1;
      check("R1 async clear", psw, 16'h0000);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 held after reset", psw, 16'h0000);

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
   end

endmodule